// File: doc/BRIEF.md
# Multiply-Based Operand Shifter

This block shifts a 24-bit signed operand left or right by a variable number of bit positions. It does not use a shifter network. It multiplies the operand by a power-of-two constant on a signed fractional 24x24 multiplier. The product of a fractional multiply is the integer product doubled. The constant for a right shift by n is therefore the fraction 2^-n, and the constant for a left shift by n is the integer 2^(n-1).

The 48-bit product goes into a 56-bit accumulator as an upper word and a lower word, with an 8-bit sign-extension word above them.

A right-shifted result is read from the upper word. A left-shifted result is read from the lower word.

The caller also selects the immediate format used to carry the constant:

- **Short format:** an 8-bit fraction in the top byte of the 24-bit multiplier register. It costs one cycle. It can only hold right-shift constants for amounts up to 7.
- **Long format:** the constant sits in the low-order bits of the register. It costs two cycles and can hold every constant.

If a request asks for the short format but its constant cannot be encoded that way, the block uses the long format instead.

Top module: `fmul_shifter`

## Requirements
- R1: While `rst_n` is low, `acc` is 0 and `done` is 0.
- R2: A right shift by n writes `acc` = sign-extended `src` times 2^(24-n). This places `src` shifted right by n in `acc[47:24]`. For example, `src`=0x060000 with n=4 gives `acc`=0x00_006000_000000.
- R3: A left shift (`dir_left`=1) by n writes `acc` = sign-extended `src` times 2^n. This places the shifted value in `acc[23:0]`. For example, `src`=0x060000 with n=4 gives `acc`=0x00_000000_600000, with the upper word 0.
- R4: Every written result is sign-extended, so `acc[55:47]` is all zeros or all ones. A negative `src` gives a negative `acc`.
- R5: A request uses the short format when `fmt_short`=1, `dir_left`=0 and the effective n is at most 7. The constant is then the byte 0x80>>n in bits 23:16. For a short-format request, `done` is high in the cycle after the clock edge that samples `start`, and `acc` holds the result in that same cycle.
- R6: For a long-format request (`fmt_short`=0):
  - The constant is 2^-n or 2^(n-1) in the low-order bits of the 24-bit register.
  - `done` stays low in the cycle after the sampling edge.
  - `done` is high in the cycle after the next edge, with the result in `acc`.
- R7: A request with `fmt_short`=1 that is a left shift, or a right shift with effective n above 7, is handled as a long-format request. It takes the R6 latency and gives the same result as R2 or R3.
- R8: The effective shift amount is clamped to the range 1 to 23. `amt`=0 acts as 1, and any `amt` above 23 acts as 23.
- R9: A `start` that arrives while a long-format request is in flight is ignored. It produces no extra `done` and does not change that request's result.
- R10: `done` is high for exactly one cycle per accepted request. `acc` changes only in cycles where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled on the rising edge |
| src | input | 24 | Signed operand to shift |
| dir_left | input | 1 | 1 = left shift, 0 = right shift |
| amt | input | 5 | Requested shift amount (clamped to 1..23) |
| fmt_short | input | 1 | Request the one-cycle short immediate format |
| acc | output | 56 | Sign-extended fractional product |
| done | output | 1 | One-cycle strobe: `acc` has just been written |

## Verification
The bench sweeps every amount from 0 to 31 in both directions with positive and negative operands, and checks both the value and the cycle in which the result appears.

Each error shows up differently:
- Forgetting the multiplier's built-in doubling leaves every result off by a factor of two.
- Using 2^n instead of 2^(n-1) for left shifts does the same.
- A bad clamp corrupts the 0 and 24-31 amounts.
- Dropping the sign extension shows up on the negative operands.

On timing, a design that honours a short request it cannot encode would return a wrong value one cycle early. A design that accepts a start while busy would emit a second `done`, or overwrite the pending result.

// File: rtl/fmul_shifter.sv
module fmul_shifter #(
  parameter int W   = 24,
  parameter int EXT = 8,
  parameter int SW  = 8,
  parameter int NW  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [W-1:0]         src,
  input  logic                 dir_left,
  input  logic [NW-1:0]        amt,
  input  logic                 fmt_short,
  output logic [2*W+EXT-1:0]   acc,
  output logic                 done
);
  localparam int ACCW = 2*W + EXT;
  localparam int PW   = 2*W;
  localparam int NMAX = W - 1;
  localparam int SMAX = SW - 1;

  logic [NW-1:0] n_lo, n_eff, lsh, bsh;
  logic [W-1:0]  k_long, k_short, k_now, k_q, src_q, op_a, op_b;
  logic [SW-1:0] k_byte;
  logic          fits_short, take, short_go, long_go, busy;
  logic signed [PW-1:0] prod;
  logic [PW-1:0] frac;
  logic [ACCW-1:0] acc_next;

  assign n_lo  = (amt == '0) ? NW'(1) : amt;
  assign n_eff = (n_lo > NW'(NMAX)) ? NW'(NMAX) : n_lo;

  assign lsh    = dir_left ? (n_eff - NW'(1)) : (NW'(NMAX) - n_eff);
  assign k_long = {{(W-1){1'b0}}, 1'b1} << lsh;

  assign bsh     = NW'(SMAX) - n_eff;
  assign k_byte  = {{(SW-1){1'b0}}, 1'b1} << bsh;
  assign k_short = {k_byte, {(W-SW){1'b0}}};

  assign fits_short = !dir_left && (n_eff <= NW'(SMAX));
  assign k_now      = (fmt_short && fits_short) ? k_short : k_long;

  assign take     = start && !busy;
  assign short_go = take && fmt_short && fits_short;
  assign long_go  = take && !(fmt_short && fits_short);

  assign op_a     = busy ? src_q : src;
  assign op_b     = busy ? k_q   : k_now;
  assign prod     = $signed(op_a) * $signed(op_b);
  assign frac     = {prod[PW-2:0], 1'b0};
  assign acc_next = {{EXT{frac[PW-1]}}, frac};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      done  <= 1'b0;
      busy  <= 1'b0;
      src_q <= '0;
      k_q   <= '0;
    end else begin
      done <= 1'b0;
      if (short_go || busy) begin
        acc  <= acc_next;
        done <= 1'b1;
      end
      if (busy) busy <= 1'b0;
      if (long_go) begin
        busy  <= 1'b1;
        src_q <= src;
        k_q   <= k_now;
      end
    end
  end
endmodule

// File: rtl/fmul_shifter_chk.sv
module fmul_shifter_chk #(
  parameter int W   = 24,
  parameter int EXT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              short_go,
  input logic              done,
  input logic [2*W+EXT-1:0] acc
);
  localparam int TOPB = EXT + 1;

  AST_SHORT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    short_go |=> done); // R5

  AST_LONG_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !short_go) |=> (busy && !done)); // R6

  AST_LONG_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy)); // R6

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !busy); // R9

  AST_SIGN_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(acc[2*W+EXT-1 -: TOPB]) == 0 ||
              $countones(acc[2*W+EXT-1 -: TOPB]) == TOPB)); // R4

  AST_ACC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(acc)); // R10
endmodule

bind fmul_shifter fmul_shifter_chk #(.W(W), .EXT(EXT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .short_go(short_go), .done(done), .acc(acc)
);

// File: tb/test_fmul_shifter.sv
module test_fmul_shifter;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [55:0] exp;
    int          due;
    string       vtag;
    string       ltag;
  } item_t;

  logic        clk = 0, rst_n = 0, start = 0, dir_left = 0, fmt_short = 0;
  logic [23:0] src = '0;
  logic [4:0]  amt = '0;
  logic [55:0] acc;
  logic        done;
  int          cyc = 0, nchk = 0, nfail = 0;
  logic [55:0] last_acc = '0;
  item_t       sb[$];

  fmul_shifter i_fmul_shifter (
    .clk(clk), .rst_n(rst_n), .start(start), .src(src), .dir_left(dir_left),
    .amt(amt), .fmt_short(fmt_short), .acc(acc), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [55:0] model(input logic [23:0] s, input logic l, input logic [4:0] a);
    int n;
    logic signed [55:0] x;
    n = (a == 0) ? 1 : ((a > 23) ? 23 : int'(a));
    x = {{32{s[23]}}, s};
    return l ? (x <<< n) : (x <<< (24 - n));
  endfunction

  task automatic issue(input logic [23:0] s, input logic l, input logic [4:0] a,
                       input logic fs, input string vt);
    int n;
    bit is_long;
    item_t it;
    n = (a == 0) ? 1 : ((a > 23) ? 23 : int'(a));
    is_long = !(fs && !l && n <= 7);
    @(negedge clk);
    src = s; dir_left = l; amt = a; fmt_short = fs; start = 1;
    it.exp = model(s, l, a);
    it.due = cyc + (is_long ? 2 : 1);
    it.vtag = vt;
    it.ltag = is_long ? ((fs) ? "R7" : "R6") : "R5";
    sb.push_back(it);
    if (is_long) begin
      @(negedge clk);
      start = 0;
    end
  endtask

  task automatic idle(input int k);
    @(negedge clk);
    start = 0;
    repeat (k - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (sb.size() == 0) begin
          nchk++; nfail++;
          $display("FAIL R9: unexpected done, acc=%h expected no result", acc);
        end else begin
          item_t it;
          it = sb.pop_front();
          nchk++;
          if (acc !== it.exp) begin
            nfail++;
            $display("FAIL %s: acc=%h expected %h", it.vtag, acc, it.exp);
          end
          nchk++;
          if (cyc != it.due) begin
            nfail++;
            $display("FAIL %s: done in cycle %0d expected %0d", it.ltag, cyc, it.due);
          end
        end
      end else if (acc !== last_acc) begin
        nchk++; nfail++;
        $display("FAIL R10: acc changed without done, acc=%h expected %h", acc, last_acc);
      end
      last_acc = acc;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not finish, cycle=%0d expected < 100000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    nchk++;
    if (acc !== '0 || done !== 1'b0) begin
      nfail++;
      $display("FAIL R1: acc=%h done=%b expected 0 and 0", acc, done);
    end
    rst_n = 1;
    idle(2);

    // R2 / R3 literal examples
    issue(24'h060000, 0, 5'd4, 1, "R2");
    idle(2);
    nchk++;
    if (acc !== 56'h00_006000_000000) begin
      nfail++; $display("FAIL R2: acc=%h expected %h", acc, 56'h00_006000_000000);
    end
    issue(24'h060000, 1, 5'd4, 0, "R3");
    idle(2);
    nchk++;
    if (acc !== 56'h00_000000_600000) begin
      nfail++; $display("FAIL R3: acc=%h expected %h", acc, 56'h00_000000_600000);
    end

    // R4 negative operands
    issue(24'hFA0000, 0, 5'd4, 1, "R4");
    issue(24'h800001, 1, 5'd23, 0, "R4");
    idle(2);

    // R5 back-to-back short requests
    for (int i = 1; i <= 7; i++) issue(24'h123456 + 24'(i), 0, 5'(i), 1, "R5");
    idle(2);

    // R7 short requested but not encodable
    issue(24'h0ABCDE, 1, 5'd3, 1, "R7");
    issue(24'hF12345, 0, 5'd12, 1, "R7");
    idle(2);

    // R8 clamp at both ends
    issue(24'h400000, 0, 5'd0, 1, "R8");
    issue(24'h7FFFFF, 1, 5'd0, 0, "R8");
    issue(24'h7FFFFF, 0, 5'd31, 0, "R8");
    issue(24'h800000, 1, 5'd24, 0, "R8");
    idle(2);

    // R2/R3 sweep of every amount, both formats
    for (int a = 0; a < 32; a++) begin
      issue(24'h5A5A5A, 0, 5'(a), 0, "R2");
      issue(24'hC3C3C3, 0, 5'(a), 1, "R2");
      issue(24'h5A5A5A, 1, 5'(a), 0, "R3");
      issue(24'hA0F00F, 1, 5'(a), 1, "R3");
    end
    idle(3);

    // R9 start while long request in flight
    @(negedge clk);
    src = 24'h111111; dir_left = 1; amt = 5'd5; fmt_short = 0; start = 1;
    begin
      item_t it;
      it.exp = model(24'h111111, 1, 5'd5);
      it.due = cyc + 2;
      it.vtag = "R9"; it.ltag = "R9";
      sb.push_back(it);
    end
    @(negedge clk);
    src = 24'h7EEEEE; dir_left = 0; amt = 5'd2; fmt_short = 1;
    @(negedge clk);
    start = 0;
    idle(5);

    nchk++;
    if (sb.size() != 0) begin
      nfail++;
      $display("FAIL R6: %0d results outstanding expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule